// File: doc/BRIEF.md
# Fully Associative Page Translation Cache with Address-Space Tags

This block caches recent virtual-to-physical page translations. It holds a small set of entries, four by default. Each entry stores a valid flag, an address-space tag, a virtual page key and a physical page value. A lookup compares the requested page and the current address-space tag against every entry at once. It returns a hit flag and the physical page in the same cycle, with no register on the way.

Translations are installed through a fill port. A fill uses the lowest-numbered free entry. When every entry is valid, the fill replaces the entry that was used longest ago. Recency is updated by fills and by lookups that hit. If the page and tag are already cached, a fill updates that entry in place. Two control inputs remove entries: a single-page invalidate, which acts only within the current address space, and a full flush.

Top module: `assoc_tlb`

## Requirements
- R1: After reset every entry is invalid. Every lookup misses, including a lookup of page 0, and `lk_ppn` reads 0.
- R2: `lk_hit` and `lk_ppn` are combinational from `lk_vpn` and `cur_asid`. A hit needs a valid entry whose key equals `lk_vpn` and whose tag equals `cur_asid`. On a miss, `lk_ppn` is 0.
- R3: An entry filled while `cur_asid` held one value never hits while `cur_asid` holds a different value.
- R4: While free entries exist, a fill writes the lowest-numbered invalid entry. From reset, successive fills therefore use entries 0, 1, 2, 3 in order.
- R5: When all entries are valid, a fill of a new page replaces the least recently used entry. Recency is renewed by a fill of an entry, and by a lookup with `lk_req` high that hits it. A lookup with `lk_req` low does not change recency.
- R6: A fill whose page and tag match a valid entry overwrites that entry's physical page. No second copy is created and no other entry is evicted.
- R7: A single-page invalidate clears the entry whose key equals `inv_vpn` and whose tag equals `cur_asid`. Entries with another tag are left valid.
- R8: A flush clears every entry's valid flag at one clock edge.
- R9: When requests coincide, the priority is flush, then invalidate, then fill. A lower-priority request in the same cycle has no effect.
- R10: Fill, invalidate and flush take effect at the next rising edge. A lookup in the same cycle still sees the old contents.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous reset, active low |
| cur_asid | input | ASID_W | Address-space tag that qualifies lookup, fill and invalidate |
| lk_req | input | 1 | Marks the lookup as a real access, so that a hit updates recency |
| lk_vpn | input | VPN_W | Virtual page to translate |
| lk_hit | output | 1 | Lookup hit |
| lk_ppn | output | PPN_W | Translated physical page, 0 on a miss |
| fill_req | input | 1 | Install a translation |
| fill_vpn | input | VPN_W | Virtual page of the translation to install |
| fill_ppn | input | PPN_W | Physical page of the translation to install |
| inv_req | input | 1 | Invalidate one page in the current address space |
| inv_vpn | input | VPN_W | Page to invalidate |
| flush_req | input | 1 | Invalidate all entries |

## Verification
The assertions assume that reset is applied before the first request. They also assume that the control inputs are stable around the clock edge, so that the match vectors sampled at the edge are the ones the update used. The single-match check relies on the in-place fill rule, so the stimulus deliberately refills pages that are already cached. Random pages are drawn from a pool of eight keys and tags from a pool of three, which keeps hits, in-place fills, evictions and cross-tag misses all frequent. Directed sequences cover the reset state, the fill order, eviction order, same-cycle priority and the one-cycle update delay.

// File: rtl/tlb_pkg.sv
package tlb_pkg;

   // action applied at the next edge, highest priority wins
   typedef enum logic [1:0] {
      ACT_NONE  = 2'd0,
      ACT_FILL  = 2'd1,
      ACT_INVAL = 2'd2,
      ACT_FLUSH = 2'd3
   } tlb_act_e;

   function automatic tlb_act_e pick_act(input logic flush, input logic inval, input logic fill);
      if (flush)      return ACT_FLUSH;
      else if (inval) return ACT_INVAL;
      else if (fill)  return ACT_FILL;
      else            return ACT_NONE;
   endfunction

endpackage

// File: rtl/tlb_match.sv
module tlb_match #(
   parameter int N  = 4,
   parameter int VW = 20,
   parameter int AW = 8
) (
   input  logic                  clk,
   input  logic                  rst_n,
   input  logic [N-1:0]          ent_valid,
   input  logic [N-1:0][VW-1:0]  ent_key,
   input  logic [N-1:0][AW-1:0]  ent_asid,
   input  logic [VW-1:0]         q_key,
   input  logic [AW-1:0]         q_asid,
   output logic [N-1:0]          hit_vec
);

   for (genvar g = 0; g < N; g++) begin : g_cmp
      assign hit_vec[g] = ent_valid[g] && (ent_key[g] == q_key) && (ent_asid[g] == q_asid);
   end

   // in-place refill keeps each (page, tag) pair unique
   assert_single_match_R6: assert property (@(posedge clk) disable iff (!rst_n)
      $onehot0(hit_vec));

endmodule

// File: rtl/tlb_lru.sv
module tlb_lru #(
   parameter int N = 4,
   localparam int IW = (N > 1) ? $clog2(N) : 1
) (
   input  logic          clk,
   input  logic          rst_n,
   input  logic          touch_en,
   input  logic [IW-1:0] touch_idx,
   input  logic [N-1:0]  ent_valid,
   output logic [IW-1:0] victim_idx
);

   logic [N-1:0][IW-1:0] age_q;
   logic [N-1:0]         oldest_vec;

   // ages form a permutation: 0 most recent, N-1 least recent
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         for (int i = 0; i < N; i++) age_q[i] <= IW'(i);
      end else if (touch_en) begin
         for (int i = 0; i < N; i++) begin
            if (IW'(i) == touch_idx)            age_q[i] <= '0;
            else if (age_q[i] < age_q[touch_idx]) age_q[i] <= age_q[i] + 1'b1;
         end
      end
   end

   for (genvar g = 0; g < N; g++) begin : g_old
      assign oldest_vec[g] = (age_q[g] == IW'(N-1));
   end

   // lowest free slot first, otherwise the oldest one
   always_comb begin
      victim_idx = '0;
      for (int i = N-1; i >= 0; i--) if (oldest_vec[i]) victim_idx = IW'(i);
      if (!(&ent_valid)) begin
         for (int i = N-1; i >= 0; i--) if (!ent_valid[i]) victim_idx = IW'(i);
      end
   end

   assert_one_oldest_R5: assert property (@(posedge clk) disable iff (!rst_n)
      $countones(oldest_vec) == 1);

   assert_victim_free_R4: assert property (@(posedge clk) disable iff (!rst_n)
      !(&ent_valid) |-> !ent_valid[victim_idx]);

endmodule

// File: rtl/assoc_tlb.sv
module assoc_tlb #(
   parameter int VPN_W   = 20,
   parameter int PPN_W   = 20,
   parameter int ASID_W  = 8,
   parameter int ENTRIES = 4
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic [ASID_W-1:0] cur_asid,
   input  logic              lk_req,
   input  logic [VPN_W-1:0]  lk_vpn,
   output logic              lk_hit,
   output logic [PPN_W-1:0]  lk_ppn,
   input  logic              fill_req,
   input  logic [VPN_W-1:0]  fill_vpn,
   input  logic [PPN_W-1:0]  fill_ppn,
   input  logic              inv_req,
   input  logic [VPN_W-1:0]  inv_vpn,
   input  logic              flush_req
);
   import tlb_pkg::*;

   localparam int IW = (ENTRIES > 1) ? $clog2(ENTRIES) : 1;

   if (ENTRIES < 2) begin : g_bad_entries
      $error("assoc_tlb: ENTRIES must be at least 2");
   end
   if (VPN_W < 1 || PPN_W < 1 || ASID_W < 1) begin : g_bad_width
      $error("assoc_tlb: field widths must be positive");
   end

   logic [ENTRIES-1:0]              valid_q;
   logic [ENTRIES-1:0][VPN_W-1:0]   key_q;
   logic [ENTRIES-1:0][PPN_W-1:0]   ppn_q;
   logic [ENTRIES-1:0][ASID_W-1:0]  asid_q;

   logic [ENTRIES-1:0] lk_match, fill_match, inv_match;
   logic [IW-1:0]      lk_idx, fill_idx, victim_idx, touch_idx;
   logic               fill_hit, touch_en;
   tlb_act_e           act;

   function automatic logic [IW-1:0] enc(input logic [ENTRIES-1:0] v);
      enc = '0;
      for (int i = 0; i < ENTRIES; i++) if (v[i]) enc = IW'(i);
   endfunction

   tlb_match #(.N(ENTRIES), .VW(VPN_W), .AW(ASID_W)) u_lk_match (
      .clk, .rst_n, .ent_valid(valid_q), .ent_key(key_q), .ent_asid(asid_q),
      .q_key(lk_vpn), .q_asid(cur_asid), .hit_vec(lk_match));

   tlb_match #(.N(ENTRIES), .VW(VPN_W), .AW(ASID_W)) u_fill_match (
      .clk, .rst_n, .ent_valid(valid_q), .ent_key(key_q), .ent_asid(asid_q),
      .q_key(fill_vpn), .q_asid(cur_asid), .hit_vec(fill_match));

   tlb_match #(.N(ENTRIES), .VW(VPN_W), .AW(ASID_W)) u_inv_match (
      .clk, .rst_n, .ent_valid(valid_q), .ent_key(key_q), .ent_asid(asid_q),
      .q_key(inv_vpn), .q_asid(cur_asid), .hit_vec(inv_match));

   // combinational read port
   assign lk_hit = |lk_match;
   assign lk_idx = enc(lk_match);
   always_comb begin
      lk_ppn = '0;
      for (int i = 0; i < ENTRIES; i++) if (lk_match[i]) lk_ppn |= ppn_q[i];
   end

   assign act      = pick_act(flush_req, inv_req, fill_req);
   assign fill_hit = |fill_match;
   assign fill_idx = fill_hit ? enc(fill_match) : victim_idx;

   // a fill's recency update takes precedence over a lookup hit
   assign touch_en  = (act == ACT_FILL) || (lk_req && lk_hit);
   assign touch_idx = (act == ACT_FILL) ? fill_idx : lk_idx;

   tlb_lru #(.N(ENTRIES)) u_lru (
      .clk, .rst_n, .touch_en, .touch_idx, .ent_valid(valid_q), .victim_idx);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         valid_q <= '0;
         key_q   <= '0;
         ppn_q   <= '0;
         asid_q  <= '0;
      end else begin
         unique case (act)
            ACT_FLUSH: valid_q <= '0;
            ACT_INVAL: valid_q <= valid_q & ~inv_match;
            ACT_FILL: begin
               valid_q[fill_idx] <= 1'b1;
               key_q[fill_idx]   <= fill_vpn;
               ppn_q[fill_idx]   <= fill_ppn;
               asid_q[fill_idx]  <= cur_asid;
            end
            default: ;
         endcase
      end
   end

   assert_flush_empties_R8: assert property (@(posedge clk) disable iff (!rst_n)
      flush_req |=> (valid_q == '0));

   assert_inval_clears_R7: assert property (@(posedge clk) disable iff (!rst_n)
      (act == ACT_INVAL) |=> ((valid_q & $past(inv_match)) == '0));

   assert_fill_lands_R10: assert property (@(posedge clk) disable iff (!rst_n)
      (act == ACT_FILL) |=> valid_q[$past(fill_idx)]);

   assert_refill_keeps_count_R6: assert property (@(posedge clk) disable iff (!rst_n)
      (act == ACT_FILL && fill_hit) |=> $stable(valid_q));

endmodule

// File: tb/test_assoc_tlb.sv
`timescale 1ns/1ps
module test_assoc_tlb;
   localparam int VW = 20, PW = 20, AW = 8, N = 4;

   logic clk = 1'b0;
   logic rst_n = 1'b0;
   logic [AW-1:0] cur_asid = '0;
   logic lk_req = 1'b0;
   logic [VW-1:0] lk_vpn = '0;
   logic lk_hit;
   logic [PW-1:0] lk_ppn;
   logic fill_req = 1'b0;
   logic [VW-1:0] fill_vpn = '0;
   logic [PW-1:0] fill_ppn = '0;
   logic inv_req = 1'b0;
   logic [VW-1:0] inv_vpn = '0;
   logic flush_req = 1'b0;

   int total = 0, bad = 0;

   always #2.5 clk = ~clk;

   assoc_tlb #(.VPN_W(VW), .PPN_W(PW), .ASID_W(AW), .ENTRIES(N)) i_assoc_tlb (
      .clk, .rst_n, .cur_asid, .lk_req, .lk_vpn, .lk_hit, .lk_ppn,
      .fill_req, .fill_vpn, .fill_ppn, .inv_req, .inv_vpn, .flush_req);

   // reference model: recency kept as a use timestamp
   bit            m_valid [N];
   logic [VW-1:0] m_vpn   [N];
   logic [PW-1:0] m_ppn   [N];
   logic [AW-1:0] m_asid  [N];
   int            m_stamp [N];
   int            now = 0;

   function automatic int m_find(input logic [VW-1:0] v, input logic [AW-1:0] a);
      for (int i = 0; i < N; i++)
         if (m_valid[i] && m_vpn[i] == v && m_asid[i] == a) return i;
      return -1;
   endfunction

   function automatic int m_slot();
      int best;
      for (int i = 0; i < N; i++) if (!m_valid[i]) return i;
      best = 0;
      for (int i = 1; i < N; i++) if (m_stamp[i] < m_stamp[best]) best = i;
      return best;
   endfunction

   task automatic m_reset();
      for (int i = 0; i < N; i++) begin
         m_valid[i] = 0; m_vpn[i] = '0; m_ppn[i] = '0; m_asid[i] = '0; m_stamp[i] = 0;
      end
   endtask

   task automatic m_edge();
      int h, s;
      bit filled;
      h = m_find(lk_vpn, cur_asid);
      filled = 0;
      if (flush_req) begin
         for (int i = 0; i < N; i++) m_valid[i] = 0;
      end else if (inv_req) begin
         s = m_find(inv_vpn, cur_asid);
         if (s >= 0) m_valid[s] = 0;
      end else if (fill_req) begin
         s = m_find(fill_vpn, cur_asid);
         if (s < 0) s = m_slot();
         m_valid[s] = 1; m_vpn[s] = fill_vpn; m_ppn[s] = fill_ppn; m_asid[s] = cur_asid;
         now++; m_stamp[s] = now;
         filled = 1;
      end
      if (!filled && lk_req && h >= 0) begin
         now++; m_stamp[h] = now;
      end
   endtask

   task automatic chk(input bit ok, input string tag, input logic [31:0] act, input logic [31:0] exp);
      total++;
      if (!ok) begin
         bad++;
         $display("FAIL %s actual=%h expected=%h", tag, act, exp);
      end
   endtask

   // compare the lookup outputs with the model (before this cycle's edge)
   task automatic cmp(input string tag);
      int h;
      logic [PW-1:0] e;
      h = m_find(lk_vpn, cur_asid);
      e = (h >= 0) ? m_ppn[h] : '0;
      chk(lk_hit == (h >= 0), {tag, " hit"}, 32'(lk_hit), 32'(h >= 0));
      chk(lk_ppn == e, {tag, " ppn"}, 32'(lk_ppn), 32'(e));
   endtask

   // called at a negedge with inputs set
   task automatic tick(input string tag);
      #1 cmp(tag);
      @(posedge clk);
      m_edge();
      @(negedge clk);
   endtask

   task automatic idle();
      lk_req = 0; fill_req = 0; inv_req = 0; flush_req = 0;
   endtask

   // read every page in the pool without touching recency
   task automatic probe(input string tag);
      idle();
      for (int v = 0; v < 8; v++) begin
         lk_vpn = VW'(v);
         tick(tag);
      end
   endtask

   task automatic do_fill(input int v, input int p, input string tag);
      idle(); fill_req = 1; fill_vpn = VW'(v); fill_ppn = PW'(p);
      tick(tag);
      idle();
   endtask

   initial begin
      repeat (150000) @(posedge clk);
      bad++;
      $display("FAIL watchdog expired");
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
   end

   initial begin
      int seed;
      seed = 32'h5eed_7a1b;
      void'($urandom(seed));
      m_reset();
      repeat (3) @(negedge clk);
      // R1: reset state, page 0 misses
      lk_vpn = '0;
      #1 chk(lk_hit == 1'b0 && lk_ppn == '0, "R1 in reset", {lk_hit, 11'd0, lk_ppn}, 32'd0);
      rst_n = 1'b1;
      @(negedge clk);
      probe("R1 after reset");

      // R4: fill order, then R5 eviction of the oldest
      cur_asid = 8'h11;
      for (int v = 1; v <= 4; v++) do_fill(v, 32'h100 + v, "R4 fill");
      probe("R4 four fills");
      do_fill(5, 32'h105, "R5 evict");
      lk_vpn = VW'(1);
      #1 chk(lk_hit == 1'b0, "R5 oldest page 1 evicted", 32'(lk_hit), 32'd0);
      @(negedge clk);
      // R5: a real lookup of page 2 renews it, so page 3 goes next
      lk_req = 1; lk_vpn = VW'(2);
      tick("R5 touch");
      do_fill(6, 32'h106, "R5 evict2");
      lk_vpn = VW'(3);
      #1 chk(lk_hit == 1'b0, "R5 page 3 evicted after touch", 32'(lk_hit), 32'd0);
      lk_vpn = VW'(2);
      #1 chk(lk_hit == 1'b1, "R5 touched page 2 kept", 32'(lk_hit), 32'd1);
      @(negedge clk);
      // R5: lk_req low does not renew recency: probe page 4, then fill evicts it
      lk_req = 0; lk_vpn = VW'(4);
      tick("R5 passive");
      do_fill(7, 32'h107, "R5 evict3");
      lk_vpn = VW'(4);
      #1 chk(lk_hit == 1'b0, "R5 passive read left page 4 oldest", 32'(lk_hit), 32'd0);
      @(negedge clk);

      // R6: refill of a cached page updates in place
      do_fill(2, 32'hABCDE, "R6 refill");
      probe("R6 after refill");

      // R3: another tag sees nothing
      cur_asid = 8'h22;
      probe("R3 other tag");
      do_fill(2, 32'h22222, "R3 fill other tag");
      // R7: invalidate under tag 0x22 leaves tag 0x11 copy
      idle(); inv_req = 1; inv_vpn = VW'(2);
      lk_vpn = VW'(2);
      tick("R10 inval same cycle");
      idle();
      lk_vpn = VW'(2);
      #1 chk(lk_hit == 1'b0, "R7 page 2 gone in tag 0x22", 32'(lk_hit), 32'd0);
      @(negedge clk);
      cur_asid = 8'h11;
      lk_vpn = VW'(2);
      #1 chk(lk_hit == 1'b1 && lk_ppn == 20'hABCDE, "R7 tag 0x11 copy kept", {12'd0, lk_ppn}, 32'hABCDE);
      @(negedge clk);

      // R9: invalidate beats fill; flush beats fill
      idle(); inv_req = 1; inv_vpn = VW'(5); fill_req = 1; fill_vpn = VW'(0); fill_ppn = 20'h0F0F0;
      tick("R9 inval+fill");
      idle();
      probe("R9 after inval+fill");
      idle(); flush_req = 1; fill_req = 1; fill_vpn = VW'(1); fill_ppn = 20'h11111;
      lk_vpn = VW'(2);
      tick("R10 flush same cycle");
      idle();
      probe("R8 R9 after flush");

      // random phase
      for (int c = 0; c < 4000; c++) begin
         int r;
         idle();
         r = int'($urandom_range(0, 99));
         if ($urandom_range(0, 19) == 0) cur_asid = AW'($urandom_range(0, 2));
         lk_req = $urandom_range(0, 1) == 1;
         lk_vpn = VW'($urandom_range(0, 7));
         if (r < 2) flush_req = 1;
         if (r >= 2 && r < 14) begin inv_req = 1; inv_vpn = VW'($urandom_range(0, 7)); end
         if (r >= 10 && r < 45) begin
            fill_req = 1; fill_vpn = VW'($urandom_range(0, 7)); fill_ppn = PW'($urandom);
         end
         tick("R2 R5 R6 random");
      end
      idle();
      probe("R2 final");

      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
   end
endmodule